// File: doc/BRIEF.md
# Serial Port FIFO-Mode Interrupt Identification

This block is the interrupt side of a 16550-compatible serial port running with its FIFOs enabled. It holds the interrupt enable, FIFO control, line control and modem control registers. It latches receiver error and modem-change events into the line and modem status registers, and runs the character timeout timer. It then resolves the pending sources into a single request line and an identification code that the host reads back. The shift registers, baud generator and FIFO storage sit outside the block. They report to it through the receive fill level, the trigger level, a character-received strobe, a bit-clock enable and a few level and pulse flags.

The host uses a byte-wide register bus with offsets 0 to 6. Offset 0 reads the receive buffer, which raises `rxPop`, and writes the transmit buffer, which raises `txPush`. The other offsets are 1 enable, 2 identification (read) or FIFO control (write), 3 line control, 4 modem control, 5 line status and 6 modem status. Offset 7 reads zero. Reads have side effects in the same clock cycle as the read strobe.

Top module: `sio_intr_ident`

## Requirements
- R1: After reset the enable register reads 0x00, the identification register 0x01, line control 0x00 and modem control 0x00. With the FIFO empty and both transmitter flags high, line status reads 0x60. Modem status reads the modem input levels in bits 7:4 and zero in bits 3:0.
- R2: After reset `sout`, `rtsN` and `dtrN` are high, and `irqOe` and `irq` are low.
- R3: Receive-data interrupt. When FIFO mode is on (FIFO control bit 0) and enable bit 0 is set, the FIFO count at or above the trigger level makes the identification register read 0xC4 and raises `irq`. With FIFO mode off, the same count raises nothing.
- R4: The receive-data indication drops as soon as the count falls below the trigger level. No host access is needed.
- R5: Receiver error pulses (lineErr bit 0 overrun, 1 parity, 2 framing, 3 break) stick in line status bits 1 to 4. Bit 7 is their OR, bit 0 is FIFO non-empty, bit 5 is `thrEmpty` and bit 6 is `txIdle`. With enable bit 2 set, the interrupt reads 0xC6 and outranks receive data. A line status read clears the error bits and the interrupt.
- R6: When the FIFO is non-empty and neither a character nor a buffer read has occurred for 4 × `charBits` bit ticks, the register reads 0xCC (timeout, enable bit 0). A receive buffer read clears it.
- R7: Every received character and every receive buffer read restarts the timeout timer.
- R8: With enable bit 1 set, a rising edge of `thrEmpty` or of the enable bit itself (while `thrEmpty` is high) raises the transmitter-empty interrupt, code 0xC2. An identification read that reports it clears it, and so does a transmit buffer write.
- R9: Modem change pulses stick in modem status bits 3:0. With enable bit 3 set they raise code 0xC0 (bit 0 low). A modem status read clears them.
- R10: The priority order, from highest to lowest, is line status, receive data, timeout, transmitter empty, modem status.
- R11: `dtrN` is the inverse of modem control bit 0, `rtsN` the inverse of bit 1, and `irqOe` equals bit 3. One cycle after line control bit 6 is set, `sout` is held low; otherwise it follows `txBit` one cycle later.
- R12: A source whose enable bit is clear never raises `irq`. The identification register then reads 0xC1 in FIFO mode.
- R13: Identification bits 7:6 read 11 when FIFO mode is on and 00 when it is off. Bits 5:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Host register write strobe |
| regRdEn | input | 1 | Host register read strobe |
| regAddr | input | 3 | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the addressed register |
| rxData | input | 8 | Head byte of the receive FIFO |
| rxFifoCount | input | CNT_W | Receive FIFO fill level |
| rxTrigLevel | input | CNT_W | Programmed receive trigger level |
| rxPop | output | 1 | Receive buffer read strobe to the FIFO |
| txPush | output | 1 | Transmit buffer write strobe to the FIFO |
| charRx | input | 1 | One-cycle pulse per received character |
| bitTick | input | 1 | Bit-clock enable for the timeout timer |
| charBits | input | CB_W | Bit ticks per character time |
| lineErr | input | 4 | Receiver error pulses |
| thrEmpty | input | 1 | Transmit holding side empty |
| txIdle | input | 1 | Transmitter fully idle |
| modemState | input | 4 | Modem input levels |
| modemDelta | input | 4 | Modem input change pulses |
| txBit | input | 1 | Serial bit from the transmit shifter |
| sout | output | 1 | Serial output |
| rtsN | output | 1 | Request-to-send, active low |
| dtrN | output | 1 | Data-terminal-ready, active low |
| irq | output | 1 | Interrupt request |
| irqOe | output | 1 | Interrupt line drive enable (low = high impedance) |

## Verification
The hardest condition to reach from the ports is the character timeout, because it needs a non-empty FIFO below its trigger level that stays untouched for a full four-character window. It must also be told apart from the case where steady character arrivals keep pushing the window back. The stimulus holds the bit-clock enable high with a short character time. It checks that no interrupt is pending part way through the window and that the timeout is reported well after it. It then sends characters at intervals shorter than the window and shows that the timeout never appears. The transmitter-empty interrupt is the next hardest, because only an edge raises it. The bench first disarms it by clearing its enable or dropping `thrEmpty`, and then creates a new rising edge.

// File: rtl/sio_intr_pkg.sv
package sio_intr_pkg;

  typedef enum logic [2:0] {
    ID_MODEM   = 3'b000,
    ID_THRE    = 3'b001,
    ID_RDA     = 3'b010,
    ID_LSR     = 3'b011,
    ID_TIMEOUT = 3'b110
  } intrId_e;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_IER  = 3'd1;
  localparam logic [2:0] ADDR_IIR  = 3'd2;
  localparam logic [2:0] ADDR_LCR  = 3'd3;
  localparam logic [2:0] ADDR_MCR  = 3'd4;
  localparam logic [2:0] ADDR_LSR  = 3'd5;
  localparam logic [2:0] ADDR_MSR  = 3'd6;

  // read side effects handed from control to datapath
  typedef struct packed {
    logic rbrRd;
    logic thrWr;
    logic iirRd;
    logic lsrRd;
    logic msrRd;
  } hostStb_t;

endpackage

// File: rtl/sio_sticky_bits.sv
module sio_sticky_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] setBits,
  input  logic         clr,
  output logic [W-1:0] q
);
  // a new event in the clearing cycle survives
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~{W{clr}}) | setBits;
  end
endmodule

// File: rtl/sio_intr_ctrl.sv
module sio_intr_ctrl
  import sio_intr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic [7:0] rxData,
  input  logic [7:0] lsrVal,
  input  logic [7:0] msrVal,
  input  logic [7:0] iirVal,
  output hostStb_t   stb,
  output logic [3:0] ierQ,
  output logic       fifoEn,
  output logic       lineBreak,
  output logic       dtrOn,
  output logic       rtsOn,
  output logic       irqGate,
  output logic [7:0] regRdData
);
  logic [7:0] fcrQ, lcrQ;
  logic [4:0] mcrQ;

  logic wrIer, wrFcr, wrLcr, wrMcr;
  assign wrIer = regWrEn && regAddr == ADDR_IER;
  assign wrFcr = regWrEn && regAddr == ADDR_IIR;
  assign wrLcr = regWrEn && regAddr == ADDR_LCR;
  assign wrMcr = regWrEn && regAddr == ADDR_MCR;

  assign stb.rbrRd = regRdEn && regAddr == ADDR_DATA;
  assign stb.thrWr = regWrEn && regAddr == ADDR_DATA;
  assign stb.iirRd = regRdEn && regAddr == ADDR_IIR;
  assign stb.lsrRd = regRdEn && regAddr == ADDR_LSR;
  assign stb.msrRd = regRdEn && regAddr == ADDR_MSR;

  always_ff @(posedge clk) begin
    if (rst) begin
      ierQ <= '0;
      fcrQ <= '0;
      lcrQ <= '0;
      mcrQ <= '0;
    end else begin
      if (wrIer) ierQ <= regWrData[3:0];
      if (wrFcr) fcrQ <= regWrData;
      if (wrLcr) lcrQ <= regWrData;
      if (wrMcr) mcrQ <= regWrData[4:0];
    end
  end

  assign fifoEn    = fcrQ[0];
  assign lineBreak = lcrQ[6];
  assign dtrOn     = mcrQ[0];
  assign rtsOn     = mcrQ[1];
  assign irqGate   = mcrQ[3];

  logic unusedBits;
  assign unusedBits = ^{fcrQ[7:1], mcrQ[2], mcrQ[4]};

  always_comb begin
    unique case (regAddr)
      ADDR_DATA: regRdData = rxData;
      ADDR_IER:  regRdData = {4'b0000, ierQ};
      ADDR_IIR:  regRdData = iirVal;
      ADDR_LCR:  regRdData = lcrQ;
      ADDR_MCR:  regRdData = {3'b000, mcrQ};
      ADDR_LSR:  regRdData = lsrVal;
      ADDR_MSR:  regRdData = msrVal;
      default:   regRdData = {7'b0, unusedBits & 1'b0};
    endcase
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.rbrRd, stb.iirRd, stb.lsrRd, stb.msrRd})); // R1
endmodule

// File: rtl/sio_intr_datapath.sv
module sio_intr_datapath
  import sio_intr_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int CB_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  hostStb_t         stb,
  input  logic [3:0]       ierQ,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] rxFifoCount,
  input  logic [CNT_W-1:0] rxTrigLevel,
  input  logic [3:0]       lineErr,
  input  logic             thrEmpty,
  input  logic             txIdle,
  input  logic [3:0]       modemState,
  input  logic [3:0]       modemDelta,
  input  logic             charRx,
  input  logic             bitTick,
  input  logic [CB_W-1:0]  charBits,
  output logic [7:0]       lsrVal,
  output logic [7:0]       msrVal,
  output logic [7:0]       iirVal,
  output logic             irqPend
);
  localparam int LIM_W = CB_W + 2;

  logic [3:0] errQ, deltaQ;

  sio_sticky_bits #(.W(4)) u_errBits (
    .clk(clk), .rst(rst), .setBits(lineErr), .clr(stb.lsrRd), .q(errQ));
  sio_sticky_bits #(.W(4)) u_deltaBits (
    .clk(clk), .rst(rst), .setBits(modemDelta), .clr(stb.msrRd), .q(deltaQ));

  logic rxNonEmpty;
  assign rxNonEmpty = rxFifoCount != '0;

  // character timeout window
  logic [LIM_W-1:0] toLimit, toTimer;
  logic toRestart, toFlag;
  assign toLimit   = {charBits, 2'b00};
  assign toRestart = charRx | stb.rbrRd | ~rxNonEmpty;

  always_ff @(posedge clk) begin
    if (rst)                           toTimer <= '0;
    else if (toRestart)                toTimer <= '0;
    else if (bitTick && toTimer < toLimit) toTimer <= toTimer + 1'b1;
  end
  assign toFlag = rxNonEmpty && charBits != '0 && toTimer >= toLimit;

  // transmitter empty: edge armed
  logic threArm, threArmQ, threPend;
  intrId_e curId;
  logic anyHit;
  assign threArm = ierQ[1] & thrEmpty;

  always_ff @(posedge clk) begin
    if (rst) begin
      threArmQ <= 1'b0;
      threPend <= 1'b0;
    end else begin
      threArmQ <= threArm;
      if (stb.thrWr || (stb.iirRd && anyHit && curId == ID_THRE))
        threPend <= 1'b0;
      else if (threArm && !threArmQ)
        threPend <= 1'b1;
    end
  end

  logic lsrHit, rdaHit, toHit, threHit, msHit;
  assign lsrHit  = ierQ[2] & (|errQ);
  assign rdaHit  = fifoEn & ierQ[0] & rxNonEmpty & (rxFifoCount >= rxTrigLevel);
  assign toHit   = fifoEn & ierQ[0] & toFlag;
  assign threHit = ierQ[1] & threPend;
  assign msHit   = ierQ[3] & (|deltaQ);

  always_comb begin
    anyHit = 1'b1;
    curId  = ID_MODEM;
    if      (lsrHit)  curId = ID_LSR;
    else if (rdaHit)  curId = ID_RDA;
    else if (toHit)   curId = ID_TIMEOUT;
    else if (threHit) curId = ID_THRE;
    else if (msHit)   curId = ID_MODEM;
    else              anyHit = 1'b0;
  end

  assign iirVal  = {fifoEn, fifoEn, 2'b00, curId, ~anyHit};
  assign irqPend = anyHit;
  assign lsrVal  = {|errQ, txIdle, thrEmpty, errQ, rxNonEmpty};
  assign msrVal  = {modemState, deltaQ};

  AST_RDA_DROP: assert property (@(posedge clk) disable iff (rst)
    (rxFifoCount < rxTrigLevel) |-> curId != ID_RDA); // R4
  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stb.lsrRd && lineErr == 4'b0000) |=> errQ == 4'b0000); // R5
  AST_TO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (charRx || stb.rbrRd) |=> !toFlag); // R7
  AST_THRE_WRCLR: assert property (@(posedge clk) disable iff (rst)
    stb.thrWr |=> !threPend); // R8
  AST_MSR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stb.msrRd && modemDelta == 4'b0000) |=> deltaQ == 4'b0000); // R9
endmodule

// File: rtl/sio_intr_ident.sv
module sio_intr_ident
  import sio_intr_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int CB_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [7:0]       rxData,
  input  logic [CNT_W-1:0] rxFifoCount,
  input  logic [CNT_W-1:0] rxTrigLevel,
  output logic             rxPop,
  output logic             txPush,
  input  logic             charRx,
  input  logic             bitTick,
  input  logic [CB_W-1:0]  charBits,
  input  logic [3:0]       lineErr,
  input  logic             thrEmpty,
  input  logic             txIdle,
  input  logic [3:0]       modemState,
  input  logic [3:0]       modemDelta,
  input  logic             txBit,
  output logic             sout,
  output logic             rtsN,
  output logic             dtrN,
  output logic             irq,
  output logic             irqOe
);
  hostStb_t   stb;
  logic [3:0] ierQ;
  logic       fifoEn, lineBreak, dtrOn, rtsOn, irqGate, irqPend;
  logic [7:0] lsrVal, msrVal, iirVal;

  sio_intr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .rxData(rxData),
    .lsrVal(lsrVal), .msrVal(msrVal), .iirVal(iirVal), .stb(stb),
    .ierQ(ierQ), .fifoEn(fifoEn), .lineBreak(lineBreak), .dtrOn(dtrOn),
    .rtsOn(rtsOn), .irqGate(irqGate), .regRdData(regRdData));

  sio_intr_datapath #(.CNT_W(CNT_W), .CB_W(CB_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .ierQ(ierQ), .fifoEn(fifoEn),
    .rxFifoCount(rxFifoCount), .rxTrigLevel(rxTrigLevel), .lineErr(lineErr),
    .thrEmpty(thrEmpty), .txIdle(txIdle), .modemState(modemState),
    .modemDelta(modemDelta), .charRx(charRx), .bitTick(bitTick),
    .charBits(charBits), .lsrVal(lsrVal), .msrVal(msrVal), .iirVal(iirVal),
    .irqPend(irqPend));

  logic soutQ;
  always_ff @(posedge clk) begin
    if (rst) soutQ <= 1'b1;
    else     soutQ <= lineBreak ? 1'b0 : txBit;
  end

  assign sout   = soutQ;
  assign rtsN   = ~rtsOn;
  assign dtrN   = ~dtrOn;
  assign irqOe  = irqGate;
  assign irq    = irqPend;
  assign rxPop  = stb.rbrRd;
  assign txPush = stb.thrWr;

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    lineBreak |=> !sout); // R11
endmodule

// File: tb/sio_intr_ident_test.sv
module sio_intr_ident_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic regWrEn = 0, regRdEn = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] regWrData = 0, regRdData, rxData = 8'h5A;
  logic [4:0] rxFifoCount = 0, rxTrigLevel = 5'd4;
  logic rxPop, txPush, charRx = 0, bitTick = 0;
  logic [7:0] charBits = 8'd4;
  logic [3:0] lineErr = 0, modemState = 4'b0101, modemDelta = 0;
  logic thrEmpty = 1, txIdle = 1, txBit = 1;
  logic sout, rtsN, dtrN, irq, irqOe;

  sio_intr_ident uut (.*);

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];
  int nChk = 0, nFail = 0;
  bit finished = 0;

  // monitor: compares queued expectations mid low phase
  initial forever begin
    @(negedge clk); #2;
    if (sbq.size() > 0) begin
      item_t it;
      logic [7:0] obs;
      it = sbq.pop_front();
      case (it.kind)
        0: obs = regRdData;
        1: obs = {7'b0, irq};
        default: obs = {4'b0, sout, irqOe, rtsN, dtrN};
      endcase
      nChk++;
      if (obs !== it.exp) begin
        nFail++;
        $display("FAIL %s: got %02h expected %02h", it.tag, obs, it.exp);
      end
    end
  end

  task automatic rdChk(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    regAddr = a; regRdEn = 1;
    sbq.push_back('{0, e, t});
    @(posedge clk); #1 regRdEn = 0;
  endtask

  task automatic sigChk(input int k, input logic [7:0] e, input string t);
    @(negedge clk);
    sbq.push_back('{k, e, t});
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(posedge clk); #1 regWrEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseRx();
    @(negedge clk); charRx = 1;
    @(posedge clk); #1 charRx = 0;
  endtask

  task automatic pulseErr(input logic [3:0] v);
    @(negedge clk); lineErr = v;
    @(posedge clk); #1 lineErr = 0;
  endtask

  task automatic pulseMs(input logic [3:0] v);
    @(negedge clk); modemDelta = v;
    @(posedge clk); #1 modemDelta = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (70) @(posedge clk);
    #1 rst = 0;
    // R1 / R2 reset values
    rdChk(3'd1, 8'h00, "R1 IER");
    rdChk(3'd2, 8'h01, "R1 IIR");
    rdChk(3'd3, 8'h00, "R1 LCR");
    rdChk(3'd4, 8'h00, "R1 MCR");
    rdChk(3'd5, 8'h60, "R1 LSR");
    rdChk(3'd6, 8'h50, "R1 MSR");
    sigChk(2, 8'h0B, "R2 pins");
    sigChk(1, 8'h00, "R2 irq");

    // R13 / R3: FIFO mode off suppresses receive data
    wr(3'd1, 8'h01);
    rxFifoCount = 5;
    rdChk(3'd2, 8'h01, "R13 IIR fifo off");
    sigChk(1, 8'h00, "R3 irq fifo off");
    wr(3'd2, 8'h01); idle(1);
    rdChk(3'd2, 8'hC4, "R3 rda");
    sigChk(1, 8'h01, "R3 irq");
    // R12 enable gating
    wr(3'd1, 8'h00); idle(1);
    rdChk(3'd2, 8'hC1, "R12 disabled");
    sigChk(1, 8'h00, "R12 irq");
    wr(3'd1, 8'h05); idle(1);
    rxFifoCount = 4;
    rdChk(3'd2, 8'hC4, "R3 at trigger");
    rxFifoCount = 3;
    rdChk(3'd2, 8'hC1, "R4 below trigger");
    // R5 line status over receive data
    rxFifoCount = 5;
    pulseErr(4'b0100);
    rdChk(3'd2, 8'hC6, "R5 lsr priority");
    rdChk(3'd5, 8'hE9, "R5 LSR framing");
    rdChk(3'd2, 8'hC4, "R5 after LSR read");
    rxFifoCount = 0;

    // R6 / R7 timeout
    wr(3'd1, 8'h01); idle(1);
    rxFifoCount = 1;
    pulseRx();
    bitTick = 1;
    idle(8);
    rdChk(3'd2, 8'hC1, "R6 inside window");
    idle(20);
    rdChk(3'd2, 8'hCC, "R6 timeout");
    sigChk(1, 8'h01, "R6 irq");
    rdChk(3'd0, 8'h5A, "R6 rbr data");
    rdChk(3'd2, 8'hC1, "R6 cleared by read");
    for (int i = 0; i < 5; i++) begin
      pulseRx();
      idle(9);
    end
    rdChk(3'd2, 8'hC1, "R7 restart by chars");
    bitTick = 0;
    rxFifoCount = 0;

    // R8 transmitter empty
    wr(3'd1, 8'h02); idle(1);
    rdChk(3'd2, 8'hC2, "R8 thre");
    rdChk(3'd2, 8'hC1, "R8 cleared by IIR read");
    thrEmpty = 0; idle(2);
    thrEmpty = 1; idle(1);
    rdChk(3'd2, 8'hC2, "R8 thre edge");
    wr(3'd0, 8'h33);
    rdChk(3'd2, 8'hC1, "R8 cleared by write");

    // R10 / R9 full priority chain
    wr(3'd1, 8'h00); idle(1);
    wr(3'd1, 8'h0F); idle(1);
    pulseMs(4'b0001);
    rdChk(3'd2, 8'hC2, "R10 thre over modem");
    rdChk(3'd2, 8'hC0, "R9 modem");
    rxFifoCount = 5;
    rdChk(3'd2, 8'hC4, "R10 rda over modem");
    pulseErr(4'b0001);
    rdChk(3'd2, 8'hC6, "R10 lsr top");
    rdChk(3'd5, 8'hE3, "R5 LSR overrun");
    rdChk(3'd2, 8'hC4, "R10 rda next");
    rxFifoCount = 0;
    rdChk(3'd2, 8'hC0, "R10 modem last");
    rdChk(3'd6, 8'h51, "R9 MSR");
    rdChk(3'd2, 8'hC1, "R9 cleared");
    sigChk(1, 8'h00, "R9 irq low");

    // R11 output pins
    wr(3'd4, 8'h0B); idle(1);
    sigChk(2, 8'h0C, "R11 mcr pins");
    wr(3'd3, 8'h40); idle(1);
    sigChk(2, 8'h04, "R11 break");
    wr(3'd3, 8'h00);
    txBit = 0; idle(2);
    sigChk(2, 8'h04, "R11 follow low");
    txBit = 1; idle(2);
    sigChk(2, 8'h0C, "R11 follow high");

    idle(3);
    finished = 1;
    summary();
    $finish;
  end
endmodule